// File: doc/BRIEF.md
# Panel Power Sequencer

The sequencer switches a flat panel's supply enable and backlight enable on and off in a safe order. Software programs four fine delays (100 µs units), a coarse minimum-off time (100 ms units) and a reference divider through a small word-addressed register port. It then asks for power by setting a target bit in the control word. The state machine walks the panel through its power-up steps and its power-down steps. Before it allows the next power-up, it always waits out the minimum-off time.

The timebase is a prescaler. It emits one fine tick every `max(divider,1)` clocks and one coarse tick every `COARSE_TICKS` fine ticks. Writes to the control word are guarded by a 16-bit key. A platform reset input can be armed to withdraw the power request. A status word reports whether the panel is fully powered, which way a sequence is moving, and whether the off-time wait is running.

States: `S_OFF` (idle, unpowered), `S_UP_VDD` (supply on, supply-up delay), `S_UP_BL` (supply-up to backlight delay), `S_ON` (powered), `S_DN_BL` (backlight off, backlight-off to supply-down delay), `S_DN_VDD` (supply off, supply-down delay), `S_CYCLE` (minimum-off wait). The transitions are:

- `S_OFF` goes to `S_UP_VDD` when target is set.
- `S_UP_VDD` goes to `S_UP_BL` when its delay expires.
- `S_UP_BL` goes to `S_ON` when its delay expires.
- Either up state goes to `S_DN_VDD` when target is cleared (abort).
- `S_ON` goes to `S_DN_BL` when target is cleared.
- `S_DN_BL` goes to `S_DN_VDD` when its delay expires.
- `S_DN_VDD` goes to `S_CYCLE` when its delay expires and the coarse count is non-zero, and to `S_OFF` otherwise.
- `S_CYCLE` goes to `S_OFF` when its delay expires.

Top module: `panel_pwr_seq`

## Requirements
- R1: Word addresses are 0 control, 1 on-delay, 2 off-delay, 3 divisor and 4 status. After reset the on-delay word reads 0x083401F4, the off-delay word reads 0x138801F4, the divisor word reads `{DIV_RESET,3'b0,5'd7}`, and the control and status words read 0. Unstored bits read 0.
- R2: A control write updates control bits 3:0 only when wr_data[31:16] equals 0xABCD. Any other key leaves the control word unchanged. Control bit 0 is target, bit 1 is power-down-on-reset, bit 2 is backlight request and bit 3 is supply override.
- R3: The on-delay word holds the supply-up count in bits 28:16 and the supply-to-backlight count in bits 12:0. After target is set, vdd_en rises one clock after the write. bl_en rises (N_up + N_upbl)·D + 2 clocks after vdd_en, where D = max(divider,1).
- R4: The off-delay word holds the supply-down count in bits 28:16 and the backlight-off count in bits 12:0. After target is cleared from the powered state, bl_en falls one clock after the write. vdd_en falls N_bloff·D + 1 clocks after bl_en.
- R5: bl_en is high only in the powered state and only while control bit 2 is set. Clearing bit 2 drops bl_en in the clock after the write.
- R6: Status bit 31 is 1 in the powered state. Bits 29:28 read 01 while powering up and 10 while powering down. Bit 27 is 1 during the minimum-off wait. The status word ignores writes.
- R7: The divisor word holds the divider in bits 31:8 and the coarse field C in bits 4:0. After vdd_en falls on power-down, a new power-up cannot raise vdd_en sooner than (N_dn·D + 1) + (C−1)·COARSE_TICKS·D + 1 + 1 clocks. The +1 term for the wait state is absent when C ≤ 1.
- R8: Clearing target during either power-up step drops vdd_en in the next clock. The sequence then still applies the supply-down delay and the minimum-off wait.
- R9: When plat_rst_req is high and control bit 1 is set, the target bit clears in the next clock and the panel powers down. With bit 1 clear, plat_rst_req has no effect.
- R10: Control bit 3 drives vdd_en high directly without starting a sequence. The status word stays 0 and bl_en stays low.
- R11: port_sel outputs on-delay bits 31:30.
- R12: Fine ticks come every max(divider,1) clocks. The prescaler restarts at each delay start, so every delay lasts exactly count·D + 1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plat_rst_req | input | 1 | Platform reset request; withdraws power when armed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| vdd_en | output | 1 | Panel supply enable |
| bl_en | output | 1 | Backlight enable |
| port_sel | output | 2 | Selected panel port code |

## Verification
- Register reads are combinational, so a written value can be checked at the falling edge right after the capturing rising edge.
- The state machine reacts one rising edge later, so the first visible change on vdd_en or bl_en after a control write is checked one falling edge after that.
- Every timed interval is measured by counting falling edges between two observed output changes. The count is compared with count·D + 1 per state, plus one clock for any pass through `S_OFF`.
- The minimum-off wait is sampled through status bit 27 on every falling edge inside the measured window.

// File: rtl/psq_pkg.sv
package psq_pkg;
    localparam int DLY_W = 13;
    localparam int DIV_W = 24;
    localparam int CYC_W = 5;
    localparam logic [15:0] CTRL_KEY = 16'hABCD;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_ON   = 3'd1;
    localparam logic [2:0] A_OFF  = 3'd2;
    localparam logic [2:0] A_DIV  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    typedef enum logic [2:0] {
        S_OFF, S_UP_VDD, S_UP_BL, S_ON, S_DN_BL, S_DN_VDD, S_CYCLE
    } psq_state_e;

    typedef struct packed {
        logic ovr;
        logic bl;
        logic pdr;
        logic tgt;
    } ctrl_t;
endpackage

// File: rtl/psq_tick.sv
module psq_tick
    import psq_pkg::*;
#(
    parameter int unsigned COARSE_TICKS = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] ref_div,
    output logic             fine_tick,
    output logic             coarse_tick
);
    localparam int SUB_W = $clog2(COARSE_TICKS + 1);

    logic [DIV_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic [DIV_W-1:0] eff_div;

    always_comb begin
        eff_div     = (ref_div == '0) ? DIV_W'(1) : ref_div;
        fine_tick   = (pre_q >= eff_div - DIV_W'(1));
        coarse_tick = fine_tick && (sub_q == SUB_W'(COARSE_TICKS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (fine_tick) begin
            pre_q <= '0;
            sub_q <= coarse_tick ? '0 : sub_q + SUB_W'(1);
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/psq_timer.sv
module psq_timer
    import psq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             dec,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (dec && cnt_q != '0)   cnt_q <= cnt_q - DLY_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psq_regs.sv
module psq_regs
    import psq_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 24'd10,
    parameter int unsigned      RST_UP    = 2100,
    parameter int unsigned      RST_UPBL  = 500,
    parameter int unsigned      RST_DN    = 5000,
    parameter int unsigned      RST_BLOFF = 500,
    parameter int unsigned      RST_CYC   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             plat_rst_req,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_addr,
    input  logic [31:0]      status_word,
    output logic [31:0]      rd_data,
    output ctrl_t            ctrl,
    output logic [1:0]       port_sel,
    output logic [DLY_W-1:0] dly_up,
    output logic [DLY_W-1:0] dly_upbl,
    output logic [DLY_W-1:0] dly_dn,
    output logic [DLY_W-1:0] dly_bloff,
    output logic [DIV_W-1:0] ref_div,
    output logic [CYC_W-1:0] cyc_field
);
    localparam int HI_LSB = 16;

    logic key_ok;
    logic unused_wr_bits;

    assign key_ok = (wr_data[31:16] == CTRL_KEY);
    assign unused_wr_bits = ^{wr_data[29], wr_data[15:13], wr_data[7:5]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            port_sel  <= '0;
            dly_up    <= DLY_W'(RST_UP);
            dly_upbl  <= DLY_W'(RST_UPBL);
            dly_dn    <= DLY_W'(RST_DN);
            dly_bloff <= DLY_W'(RST_BLOFF);
            ref_div   <= DIV_RESET;
            cyc_field <= CYC_W'(RST_CYC);
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    A_CTRL: if (key_ok) ctrl <= ctrl_t'(wr_data[3:0]);
                    A_ON: begin
                        port_sel <= wr_data[31:30];
                        dly_up   <= wr_data[HI_LSB +: DLY_W];
                        dly_upbl <= wr_data[DLY_W-1:0];
                    end
                    A_OFF: begin
                        dly_dn    <= wr_data[HI_LSB +: DLY_W];
                        dly_bloff <= wr_data[DLY_W-1:0];
                    end
                    A_DIV: begin
                        ref_div   <= wr_data[31:8];
                        cyc_field <= wr_data[CYC_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (plat_rst_req && ctrl.pdr) ctrl.tgt <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = {28'b0, ctrl};
            A_ON:    rd_data = {port_sel, 1'b0, dly_up, 3'b0, dly_upbl};
            A_OFF:   rd_data = {3'b0, dly_dn, 3'b0, dly_bloff};
            A_DIV:   rd_data = {ref_div, 3'b0, cyc_field};
            A_STAT:  rd_data = status_word;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
    import psq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [DLY_W-1:0] dly_up,
    input  logic [DLY_W-1:0] dly_upbl,
    input  logic [DLY_W-1:0] dly_dn,
    input  logic [DLY_W-1:0] dly_bloff,
    input  logic [CYC_W-1:0] cyc_field,
    input  logic             done,
    output logic             load,
    output logic [DLY_W-1:0] load_val,
    output logic             coarse_mode,
    output logic             vdd_en,
    output logic             bl_en,
    output logic [31:0]      status_word,
    output psq_state_e       state
);
    psq_state_e       nxt;
    logic [DLY_W-1:0] cyc_units;
    logic             powered;
    logic [1:0]       prog;

    // field values 0 and 1 both mean "no wait"
    assign cyc_units = (cyc_field > CYC_W'(1))
                     ? {{(DLY_W-CYC_W){1'b0}}, cyc_field - CYC_W'(1)} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            S_OFF: if (ctrl.tgt) begin
                nxt = S_UP_VDD; load = 1'b1; load_val = dly_up;
            end
            S_UP_VDD: if (!ctrl.tgt) begin
                nxt = S_DN_VDD; load = 1'b1; load_val = dly_dn;
            end else if (done) begin
                nxt = S_UP_BL; load = 1'b1; load_val = dly_upbl;
            end
            S_UP_BL: if (!ctrl.tgt) begin
                nxt = S_DN_VDD; load = 1'b1; load_val = dly_dn;
            end else if (done) begin
                nxt = S_ON;
            end
            S_ON: if (!ctrl.tgt) begin
                nxt = S_DN_BL; load = 1'b1; load_val = dly_bloff;
            end
            S_DN_BL: if (done) begin
                nxt = S_DN_VDD; load = 1'b1; load_val = dly_dn;
            end
            S_DN_VDD: if (done) begin
                if (cyc_units != '0) begin
                    nxt = S_CYCLE; load = 1'b1; load_val = cyc_units;
                end else begin
                    nxt = S_OFF;
                end
            end
            S_CYCLE: if (done) nxt = S_OFF;
            default: nxt = S_OFF;
        endcase
    end

    always_comb begin
        vdd_en      = ctrl.ovr;
        bl_en       = 1'b0;
        powered     = 1'b0;
        prog        = 2'b00;
        coarse_mode = 1'b0;
        unique case (state)
            S_OFF:    ;
            S_UP_VDD: begin vdd_en = 1'b1; prog = 2'b01; end
            S_UP_BL:  begin vdd_en = 1'b1; prog = 2'b01; end
            S_ON:     begin vdd_en = 1'b1; bl_en = ctrl.bl; powered = 1'b1; end
            S_DN_BL:  begin vdd_en = 1'b1; prog = 2'b10; end
            S_DN_VDD: prog = 2'b10;
            S_CYCLE:  coarse_mode = 1'b1;
            default:  ;
        endcase
        status_word = {powered, 1'b0, prog, coarse_mode, 27'b0};
    end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import psq_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET    = 24'd10,
    parameter int unsigned      COARSE_TICKS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        plat_rst_req,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        vdd_en,
    output logic        bl_en,
    output logic [1:0]  port_sel
);
    ctrl_t            ctrl_q;
    logic [DLY_W-1:0] dly_up, dly_upbl, dly_dn, dly_bloff, load_val;
    logic [DIV_W-1:0] ref_div;
    logic [CYC_W-1:0] cyc_field;
    logic [31:0]      status_word;
    logic             load, done, coarse_mode, fine_tick, coarse_tick;
    psq_state_e       fsm_state;

    psq_regs #(.DIV_RESET(DIV_RESET)) u_regs (
        .clk, .rst_n, .plat_rst_req, .wr_en, .wr_addr, .wr_data, .rd_addr,
        .status_word, .rd_data, .ctrl(ctrl_q), .port_sel,
        .dly_up, .dly_upbl, .dly_dn, .dly_bloff, .ref_div, .cyc_field
    );

    psq_tick #(.COARSE_TICKS(COARSE_TICKS)) u_tick (
        .clk, .rst_n, .clear(load), .ref_div, .fine_tick, .coarse_tick
    );

    psq_timer u_timer (
        .clk, .rst_n, .load, .load_val,
        .dec(coarse_mode ? coarse_tick : fine_tick), .done
    );

    psq_fsm u_fsm (
        .clk, .rst_n, .ctrl(ctrl_q), .dly_up, .dly_upbl, .dly_dn, .dly_bloff,
        .cyc_field, .done, .load, .load_val, .coarse_mode, .vdd_en, .bl_en,
        .status_word, .state(fsm_state)
    );
endmodule

// File: rtl/psq_chk.sv
module psq_chk
    import psq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        plat_rst_req,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        vdd_en,
    input logic        bl_en,
    input psq_state_e  state,
    input ctrl_t       ctrl
);
    a_r5_bl_needs_vdd: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |-> vdd_en);

    a_r4_bl_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_en) |-> !$past(bl_en));

    a_r7_cycle_blocks_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CYCLE) |=> (state != S_UP_VDD));

    a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && wr_data[31:16] != CTRL_KEY && !plat_rst_req)
        |=> $stable(ctrl));

    a_r9_pdr_clears_target: assert property (@(posedge clk) disable iff (!rst_n)
        (plat_rst_req && ctrl.pdr) |=> !ctrl.tgt);

    a_r8_abort_up: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_UP_VDD || state == S_UP_BL) && !ctrl.tgt) |=> (state == S_DN_VDD));
endmodule

bind panel_pwr_seq psq_chk u_psq_chk (
    .clk(clk), .rst_n(rst_n), .plat_rst_req(plat_rst_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .vdd_en(vdd_en), .bl_en(bl_en),
    .state(fsm_state), .ctrl(ctrl_q)
);

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        plat_rst_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        vdd_en, bl_en;
    logic [1:0]  port_sel;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_pwr_seq #(.DIV_RESET(24'd3), .COARSE_TICKS(4)) i_panel_pwr_seq (
        .clk, .rst_n, .plat_rst_req, .wr_en, .wr_addr, .wr_data, .rd_addr,
        .rd_data, .vdd_en, .bl_en, .port_sel
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  wa;
        logic [31:0] wd;
        logic [2:0]  ra;
        logic [31:0] ex;
    } vec_t;

    // R1 reset values, R2 key guard, R3/R4/R7 field storage, R6 read-only status
    localparam vec_t VECS [0:12] = '{
        '{1'b0, 3'd0, 32'h0,         3'd1, 32'h083401F4},
        '{1'b0, 3'd0, 32'h0,         3'd2, 32'h138801F4},
        '{1'b0, 3'd0, 32'h0,         3'd3, 32'h00000307},
        '{1'b0, 3'd0, 32'h0,         3'd0, 32'h00000000},
        '{1'b0, 3'd0, 32'h0,         3'd4, 32'h00000000},
        '{1'b1, 3'd0, 32'h1234_0004, 3'd0, 32'h00000000},
        '{1'b1, 3'd0, 32'hABCD_0004, 3'd0, 32'h00000004},
        '{1'b1, 3'd0, 32'h0000_0000, 3'd0, 32'h00000004},
        '{1'b1, 3'd0, 32'hABCD_FFF0, 3'd0, 32'h00000000},
        '{1'b1, 3'd1, 32'hA005_E003, 3'd1, 32'h80050003},
        '{1'b1, 3'd2, 32'hE004_E002, 3'd2, 32'h00040002},
        '{1'b1, 3'd3, 32'h0000_02E3, 3'd3, 32'h00000203},
        '{1'b1, 3'd4, 32'hFFFF_FFFF, 3'd4, 32'h00000000}
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_bl(input logic v);
        for (int i = 0; i < 2000 && bl_en !== v; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        rd_addr = 3'd4;
        for (int i = 0; i < 2000 && (rd_data !== 32'h0 || vdd_en); i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int  cnt;
        bit  seen;
        repeat (3) @(negedge clk);
        check("R1 vdd_en reset", 32'(vdd_en), 32'h0);
        check("R1 bl_en reset", 32'(bl_en), 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < 13; v++) begin
            if (VECS[v].we) wr(VECS[v].wa, VECS[v].wd);
            else @(negedge clk);
            rd_addr = VECS[v].ra;
            #1;
            check($sformatf("R1/R2/R6 vector %0d", v), rd_data, VECS[v].ex);
        end

        check("R11 port_sel", 32'(port_sel), 32'h2);
        rd_addr = 3'd4;

        // R3 power-up order: D=2, N_up=5, N_upbl=3 -> 18 clocks
        wr(3'd0, 32'hABCD_0005);
        check("R3 vdd low before fsm edge", 32'(vdd_en), 32'h0);
        @(negedge clk);
        check("R3 vdd rises one clock after write", 32'(vdd_en), 32'h1);
        check("R6 status powering up", rd_data, 32'h1000_0000);
        cnt = 0;
        while (!bl_en && cnt < 1000) begin @(negedge clk); cnt++; end
        check("R3/R12 vdd-to-backlight clocks", 32'(cnt), 32'd18);
        check("R6 status powered", rd_data, 32'h8000_0000);

        // R5 backlight request bit
        wr(3'd0, 32'hABCD_0001);
        check("R5 bl drops with request bit", 32'(bl_en), 32'h0);
        check("R5 vdd stays", 32'(vdd_en), 32'h1);
        wr(3'd0, 32'hABCD_0005);
        check("R5 bl returns with request bit", 32'(bl_en), 32'h1);

        // R4 power-down order, R7 off-time with C=3 -> 2 coarse units
        wr(3'd0, 32'hABCD_0004);
        check("R4 bl before fsm edge", 32'(bl_en), 32'h1);
        @(negedge clk);
        check("R4 bl falls first", 32'(bl_en), 32'h0);
        check("R4 vdd still on", 32'(vdd_en), 32'h1);
        check("R6 status powering down", rd_data, 32'h2000_0000);
        cnt = 0;
        wr(3'd0, 32'hABCD_0005);
        cnt = 2;
        while (vdd_en && cnt < 100) begin @(negedge clk); cnt++; end
        check("R4 backlight-off to vdd-off clocks", 32'(cnt), 32'd5);
        cnt = 0; seen = 0;
        while (!vdd_en && cnt < 500) begin
            @(negedge clk); cnt++;
            if (rd_data[27]) seen = 1;
        end
        check("R7 vdd off-to-on clocks with wait", 32'(cnt), 32'd27);
        check("R6 off-time status bit seen", 32'(seen), 32'h1);
        wait_bl(1'b1);

        // R7 field value 1 means no wait
        wr(3'd3, 32'h0000_0201);
        wr(3'd0, 32'hABCD_0004);
        wr(3'd0, 32'hABCD_0005);
        for (int i = 0; i < 100 && vdd_en; i++) @(negedge clk);
        cnt = 0; seen = 0;
        while (!vdd_en && cnt < 500) begin
            @(negedge clk); cnt++;
            if (rd_data[27]) seen = 1;
        end
        check("R7 vdd off-to-on clocks no wait", 32'(cnt), 32'd10);
        check("R7 no off-time status", 32'(seen), 32'h0);
        wait_bl(1'b1);

        // R8 abort during power-up still applies off-time
        wr(3'd0, 32'hABCD_0000);
        wait_idle();
        wr(3'd3, 32'h0000_0203);
        wr(3'd0, 32'hABCD_0001);
        @(negedge clk);
        check("R8 vdd up", 32'(vdd_en), 32'h1);
        repeat (3) @(negedge clk);
        wr(3'd0, 32'hABCD_0000);
        @(negedge clk);
        check("R8 vdd drops on abort", 32'(vdd_en), 32'h0);
        check("R8 status powering down", rd_data, 32'h2000_0000);
        check("R8 backlight never on", 32'(bl_en), 32'h0);
        cnt = 0;
        while (rd_data != 32'h0 && cnt < 500) begin @(negedge clk); cnt++; end
        check("R8 abort down plus off-time clocks", 32'(cnt), 32'd26);

        // R10 override
        wr(3'd0, 32'hABCD_0008);
        check("R10 override raises vdd", 32'(vdd_en), 32'h1);
        @(negedge clk);
        check("R10 no sequence started", rd_data, 32'h0);
        check("R10 backlight low", 32'(bl_en), 32'h0);
        wr(3'd0, 32'hABCD_0000);
        check("R10 override release", 32'(vdd_en), 32'h0);

        // R9 platform reset request
        wr(3'd0, 32'hABCD_0005);
        wait_bl(1'b1);
        @(negedge clk); plat_rst_req = 1'b1;
        @(negedge clk); plat_rst_req = 1'b0;
        @(negedge clk);
        rd_addr = 3'd0; #1;
        check("R9 unarmed request ignored ctrl", rd_data, 32'h5);
        check("R9 unarmed request ignored bl", 32'(bl_en), 32'h1);
        wr(3'd0, 32'hABCD_0007);
        @(negedge clk); plat_rst_req = 1'b1;
        @(negedge clk); plat_rst_req = 1'b0;
        #1;
        check("R9 armed request clears target", rd_data, 32'h6);
        check("R9 bl before fsm edge", 32'(bl_en), 32'h1);
        @(negedge clk);
        check("R9 armed request powers down", 32'(bl_en), 32'h0);

        // R1 reset mid-operation
        rst_n = 1'b0;
        #1;
        check("R1 ctrl after reset", rd_data, 32'h0);
        check("R1 vdd after reset", 32'(vdd_en), 32'h0);
        rd_addr = 3'd1; #1;
        check("R1 on-delay after reset", rd_data, 32'h083401F4);
        @(negedge clk);
        rst_n = 1'b1;

        summary();
        $finish;
    end
endmodule